// File: doc/BRIEF.md
# Memory Readback Signature Checker

This block confirms that a read-only program memory holds the contents it should. On a start pulse it clears an 8-bit multiple-input signature register and reads a range of words. The range begins at a given address and covers a given number of words. Each word is folded into the register as it arrives. After the last word it raises a done flag and compares the final signature with a golden value on an input port. A match means the memory was loaded correctly and reads back cleanly. A mismatch means a fault.

The memory port is synchronous with one cycle of read latency. Words wider than a byte are folded one byte at a time, least significant byte first. The upper slice is padded with zeros. Each word takes one fetch cycle, one capture cycle and one fold cycle per byte slice. Producing the golden value and writing the memory are left to other logic.

Top module: `mem_sig_checker`

## Requirements
- R1: A start pulse accepted while idle or done clears the signature to 0x00 on the same edge and lowers done.
- R2: A scan reads addresses base, base+1, ... in ascending order, exactly once each, one read per word-count word. mem_rd is high for a single cycle per read, and two reads are never in adjacent cycles.
- R3: Each byte b is folded as s_next = {s[6:0],0} XOR (s[7] ? 0x71 : 0x00) XOR b. The taps 0x71 come from x^8+x^6+x^5+x^4+1. An all-zero region leaves the signature at 0x00.
- R4: A word of DATA_W bits (14 by default) is split into ceil(DATA_W/8) byte slices. Bits [7:0] are folded first, then bits [15:8], with the bits above DATA_W taken as zero.
- R5: Done rises 4*N clock edges after the edge that samples start, for N words with two slices. A word count of 0 gives done on the next edge with signature 0x00.
- R6: Done and the signature hold their values until the next accepted start.
- R7: pass is 1 only while done is high and the signature equals ref_sig. It is 0 at all other times.
- R8: A start pulse during a running scan is ignored. The scan keeps its range and yields the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a scan |
| base_addr | input | ADDR_W | First address to read |
| word_cnt | input | CNT_W | Number of words to read |
| ref_sig | input | 8 | Golden signature |
| mem_rd | output | 1 | Read strobe to the memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Read data, valid one cycle after mem_rd |
| done | output | 1 | Scan complete; held until next start |
| pass | output | 1 | Signature matches ref_sig while done |
| signature | output | 8 | Current signature register |

## Verification
The fold is tried with a mixed region of changing words, an all-zero region and an all-ones region. The mixed region shows whether the taps are right. The all-zero region shows that a leftover signature is cleared. The all-ones region exercises the padding of the upper slice. A single word with different low and high bytes shows whether the slice order is right. An empty range, a start pulse in the middle of a scan and a wrong golden value cover the edge of the sequencing and the compare.

// File: rtl/msig_pkg.sv
package msig_pkg;
  localparam int SIG_W = 8;
  localparam logic [SIG_W-1:0] SIG_TAPS = 8'h71;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FOLD  = 3'd3,
    ST_DONE  = 3'd4
  } scan_state_e;

  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] s,
                                                 input logic [SIG_W-1:0] b);
    logic [SIG_W-1:0] t;
    t = {s[SIG_W-2:0], 1'b0};
    if (s[SIG_W-1]) t = t ^ SIG_TAPS;
    return t ^ b;
  endfunction
endpackage

// File: rtl/misr_core.sv
module misr_core
  import msig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SIG_W-1:0] din,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-1:0] sig_q, sig_n;

  always_comb begin
    sig_n = sig_q;
    if (clr)     sig_n = '0;
    else if (en) sig_n = sig_step(sig_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sig_q <= '0;
    else if (clr | en) sig_q <= sig_n;
  end

  assign sig = sig_q;

  // R1: a clear leaves the register at zero on the next cycle
  a_r1_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0));
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import msig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 9,
  parameter int NSLICE = 2,
  localparam int SL_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              latch_word,
  output logic              fold_en,
  output logic [SL_W-1:0]   slice_idx,
  output logic              clr,
  output logic              done
);
  scan_state_e       state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [SL_W-1:0]   slice_q, slice_n;
  logic              accept;

  assign accept = start & ((state_q == ST_IDLE) | (state_q == ST_DONE));

  always_comb begin
    state_n    = state_q;
    addr_n     = addr_q;
    left_n     = left_q;
    slice_n    = slice_q;
    mem_rd     = 1'b0;
    latch_word = 1'b0;
    fold_en    = 1'b0;
    clr        = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          clr     = 1'b1;
          addr_n  = base_addr;
          left_n  = word_cnt;
          state_n = (word_cnt == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_rd  = 1'b1;
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        latch_word = 1'b1;
        slice_n    = '0;
        state_n    = ST_FOLD;
      end
      ST_FOLD: begin
        fold_en = 1'b1;
        if (slice_q == SL_W'(NSLICE - 1)) begin
          addr_n  = addr_q + 1'b1;
          left_n  = left_q - 1'b1;
          state_n = (left_q == CNT_W'(1)) ? ST_DONE : ST_FETCH;
        end else begin
          slice_n = slice_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      slice_q <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      left_q  <= left_n;
      slice_q <= slice_n;
    end
  end

  assign mem_addr  = addr_q;
  assign slice_idx = slice_q;
  assign done      = (state_q == ST_DONE);

  // checker-side tracking of the previous read address
  logic [ADDR_W-1:0] prev_rd_q;
  logic              seen_rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q <= '0;
      seen_rd_q <= 1'b0;
    end else if (accept) begin
      seen_rd_q <= 1'b0;
    end else if (mem_rd) begin
      prev_rd_q <= mem_addr;
      seen_rd_q <= 1'b1;
    end
  end

  // R2: reads within one scan step upward by one address
  a_r2_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && seen_rd_q) |-> (mem_addr == prev_rd_q + 1'b1));

  // R2: read strobes never sit in adjacent cycles
  a_r2_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6: done stays up until a new start
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/mem_sig_checker.sv
module mem_sig_checker
  import msig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 14,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic [7:0]        ref_sig,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic [7:0]        signature
);
  localparam int NSLICE = (DATA_W + SIG_W - 1) / SIG_W;
  localparam int PAD_W  = NSLICE * SIG_W;
  localparam int SL_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  logic              latch_word, fold_en, clr;
  logic [SL_W-1:0]   slice_idx;
  logic [DATA_W-1:0] word_q;
  logic [PAD_W-1:0]  word_pad;
  logic [SIG_W-1:0]  slices [NSLICE];
  logic [SIG_W-1:0]  fold_byte;

  scan_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NSLICE(NSLICE)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .word_cnt(word_cnt),
    .mem_rd(mem_rd), .mem_addr(mem_addr),
    .latch_word(latch_word), .fold_en(fold_en), .slice_idx(slice_idx),
    .clr(clr), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (latch_word) word_q <= mem_rdata;
  end

  always_comb begin
    word_pad = '0;
    word_pad[DATA_W-1:0] = word_q;
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign slices[g] = word_pad[g*SIG_W +: SIG_W];
  end

  always_comb begin
    fold_byte = '0;
    for (int k = 0; k < NSLICE; k++)
      if (slice_idx == SL_W'(k)) fold_byte = slices[k];
  end

  misr_core i_misr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(fold_en),
    .din(fold_byte), .sig(signature)
  );

  assign pass = done & (signature == ref_sig);
endmodule

// File: tb/test_mem_sig_checker.sv
module test_mem_sig_checker;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 14;
  localparam int CNT_W  = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  word_cnt;
  logic [7:0]        ref_sig;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              done, pass;
  logic [7:0]        signature;

  int errors = 0;
  int checks = 0;

  logic [DATA_W-1:0] mem [256];
  int rd_count;
  int rd_first, rd_last;

  always #5 clk = ~clk;

  mem_sig_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_mem_sig_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_cnt(word_cnt), .ref_sig(ref_sig), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .pass(pass), .signature(signature)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      if (rd_count == 0) rd_first = int'(mem_addr);
      rd_last  = int'(mem_addr);
      rd_count = rd_count + 1;
    end
  end

  function automatic logic [7:0] ref_step(input logic [7:0] s, input logic [7:0] b);
    logic [7:0] r;
    r = {s[6:0], 1'b0} ^ b;
    if (s[7]) r = r ^ 8'h71;
    return r;
  endfunction

  function automatic logic [7:0] exp_sig(input int b, input int n);
    logic [7:0] s = 8'h00;
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin
      w = {2'b00, mem[(b + i) & 255]};
      s = ref_step(s, w[7:0]);
      s = ref_step(s, w[15:8]);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_scan(input int b, input int n, output int cycles);
    @(negedge clk);
    rd_count = 0;
    base_addr = ADDR_W'(b);
    word_cnt = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R6 reset done", int'(done), 0);
    check(pass == 1'b0, "R7 reset pass", int'(pass), 0);
    check(mem_rd == 1'b0, "R2 reset mem_rd", int'(mem_rd), 0);
    check(signature == 8'h00, "R1 reset signature", int'(signature), 0);
  endtask

  task automatic t_mixed();
    int cyc;
    logic [7:0] e;
    e = exp_sig(3, 10);
    ref_sig = e;
    run_scan(3, 10, cyc);
    check(cyc == 41, "R5 latency", cyc, 41);
    check(signature == e, "R3 mixed signature", int'(signature), int'(e));
    check(rd_count == 10, "R2 read count", rd_count, 10);
    check(rd_first == 3 && rd_last == 12, "R2 first/last address", rd_first*256 + rd_last, 3*256 + 12);
    check(pass == 1'b1, "R7 pass on match", int'(pass), 1);
    ref_sig = e ^ 8'h01;
    #1;
    check(pass == 1'b0, "R7 fail on mismatch", int'(pass), 0);
  endtask

  task automatic t_zero_region();
    int cyc;
    ref_sig = 8'h00;
    run_scan(100, 8, cyc);
    check(signature == 8'h00, "R1 R3 zero region clears old signature", int'(signature), 0);
    check(pass == 1'b1, "R7 pass zero", int'(pass), 1);
  endtask

  task automatic t_ones_region();
    int cyc;
    logic [7:0] e;
    e = exp_sig(120, 5);
    run_scan(120, 5, cyc);
    check(signature == e, "R4 ones region padding", int'(signature), int'(e));
  endtask

  task automatic t_order();
    int cyc;
    logic [7:0] e;
    e = ref_step(ref_step(8'h00, 8'h5C), 8'h2A);
    run_scan(200, 1, cyc);
    check(signature == e, "R4 low byte first", int'(signature), int'(e));
    check(cyc == 5, "R5 single word latency", cyc, 5);
  endtask

  task automatic t_hold();
    logic [7:0] s0;
    s0 = signature;
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R6 done held", int'(done), 1);
    check(signature == s0, "R6 signature held", int'(signature), int'(s0));
    check(mem_rd == 1'b0 && rd_count == 1, "R6 no reads while done", rd_count, 1);
  endtask

  task automatic t_ignore();
    int cyc;
    logic [7:0] e;
    e = exp_sig(20, 6);
    run_scan_with_intrusion(cyc);
    check(signature == e, "R8 signature unchanged by start", int'(signature), int'(e));
    check(rd_count == 6, "R8 read count unchanged", rd_count, 6);
    check(rd_first == 20, "R8 range unchanged", rd_first, 20);
  endtask

  task automatic run_scan_with_intrusion(output int cycles);
    @(negedge clk);
    rd_count = 0;
    base_addr = 8'd20;
    word_cnt = 9'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    base_addr = 8'd90;
    word_cnt = 9'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 8;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_empty();
    int cyc;
    ref_sig = 8'h00;
    run_scan(50, 0, cyc);
    check(cyc == 1, "R5 empty latency", cyc, 1);
    check(signature == 8'h00, "R5 empty signature", int'(signature), 0);
    check(rd_count == 0, "R5 empty no reads", rd_count, 0);
    check(pass == 1'b1, "R7 empty pass", int'(pass), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = DATA_W'((i * 37 + 11) ^ (i << 5));
    for (int i = 100; i < 108; i++) mem[i] = '0;
    for (int i = 120; i < 125; i++) mem[i] = '1;
    mem[200] = 14'h2A5C;
    rd_count = 0;
    rd_first = 0;
    rd_last = 0;
    rst_n = 1'b0;
    start = 1'b0;
    base_addr = '0;
    word_cnt = '0;
    ref_sig = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mixed();
    t_zero_region();
    t_ones_region();
    t_order();
    t_hold();
    t_ignore();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule